// File: doc/BRIEF.md
# Aggregated Bitmap Set Tracker

The block holds a set drawn from a fixed universe of `N` elements. It answers four commands: insert an element, remove an element, ask whether an element is present, and return some present element. Each element has one presence bit in a bank of leaf words, each `W` bits wide. A binary tree of count nodes sits above the leaf words. Every node records how many members lie under its left child and how many lie under its right child.

Each tree level is held in its own register bank. A command moves down one level per clock, from the root to the leaves. Every level can therefore serve a different command in the same cycle, and the block accepts one command per clock with no stall.

Insert and remove must know whether the leaf bit will actually change before they touch any count. The block reads the leaf bit when it accepts the command. It corrects that reading with the commands still in flight, so that an insert of a present element, or a removal of an absent one, leaves every count untouched.

A find descends left wherever the left count is nonzero. It therefore returns the lowest member of the set. If the root shows no members, the find reports a miss.

Top module: `abm_set_tracker`

## Requirements
- R1: After reset the set is empty: every test misses, a find misses, and no response is pending.
- R2: Opcode 0 (add) inserts the index. Its response has hit=1 when the element was absent and has now been inserted. The index is echoed.
- R3: An add of an element that is already present returns hit=0 and leaves the set unchanged.
- R4: Opcode 1 (delete) removes the index. It returns hit=1 when the element was present and hit=0 when it was absent, and the index is echoed.
- R5: Opcode 2 (test) returns hit=1 exactly when the index is in the set, and the index is echoed.
- R6: Opcode 3 (find) returns hit=1 and the smallest member of the set. On an empty set it returns hit=0 with index 0.
- R7: `cmd_ready_o` is always 1. Each accepted command yields exactly one response, in issue order. The response is valid in the cycle after the log2(N/W)-th rising edge that follows the accepting edge.
- R8: Commands issued back to back on the same index see the effect of every earlier command, even while those commands are still in flight.
- R9: No count field underflows on a removal or exceeds the size of its subtree on an insert. Counts change only when a leaf bit changes.
- R10: A find that reports a hit always reaches a leaf word that holds at least one member.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears every bank |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted (always 1) |
| cmd_op_i | input | 2 | 0 add, 1 delete, 2 test, 3 find |
| cmd_idx_i | input | log2(N) | Element index (ignored by find) |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Inserted / removed / present / found |
| rsp_idx_o | output | log2(N) | Echoed index, or the member found |

## Verification
With the defaults (N=128, W=16) there are three count levels, so each response is due exactly three rising edges after the edge that accepted the command.

The bench drives commands on falling edges. When it drives a command, it records the cycle number at which the response is due, based on an edge counter. On every falling edge it compares `rsp_valid_o` with "the oldest pending entry is due now". When a response is due, it also compares the hit flag and the index.

The expected values come from a behavioural bit-array model. The model is updated in issue order, so the same-index bursts of R8 are judged on sequential semantics, even though the hardware is still resolving those commands through forwarding.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_DEL  = 2'd1,
    OP_TEST = 2'd2,
    OP_FIND = 2'd3
  } abm_op_e;
endpackage

// File: rtl/abm_level.sv
module abm_level
  import abm_pkg::*;
#(
  parameter int N   = 128,
  parameter int LVL = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   v_i,
  input  abm_op_e                op_i,
  input  logic [$clog2(N)-1:0]   idx_i,
  input  logic                   chg_i,
  input  logic                   hit_i,
  output logic                   v_o,
  output abm_op_e                op_o,
  output logic [$clog2(N)-1:0]   idx_o,
  output logic                   chg_o,
  output logic                   hit_o
);
  localparam int IW = $clog2(N);
  localparam int CW = IW + 1;
  localparam int NB = (LVL == 0) ? 1 : LVL;
  localparam int NN = 1 << NB;
  localparam logic [CW-1:0] CAP = CW'(N >> (LVL + 1));

  logic [CW-1:0] lcnt_q [NN];
  logic [CW-1:0] rcnt_q [NN];
  logic [NB-1:0] nd;
  logic          br;
  logic [IW-1:0] idx_n;
  logic          hit_n;
  logic [CW-1:0] sel_cnt;

  always_comb begin
    nd    = NB'(idx_i >> (IW - LVL));
    // find steers left while the left subtree holds a member
    br    = (op_i == OP_FIND) ? (lcnt_q[nd] == '0) : idx_i[IW-1-LVL];
    idx_n = idx_i;
    if (op_i == OP_FIND) idx_n[IW-1-LVL] = br;
    hit_n = hit_i;
    if (LVL == 0 && op_i == OP_FIND && lcnt_q[nd] == '0 && rcnt_q[nd] == '0)
      hit_n = 1'b0;
    sel_cnt = br ? rcnt_q[nd] : lcnt_q[nd];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NN; k++) begin
        lcnt_q[k] <= '0;
        rcnt_q[k] <= '0;
      end
      v_o   <= 1'b0;
      op_o  <= OP_ADD;
      idx_o <= '0;
      chg_o <= 1'b0;
      hit_o <= 1'b0;
    end else begin
      v_o   <= v_i;
      op_o  <= op_i;
      idx_o <= idx_n;
      chg_o <= chg_i;
      hit_o <= hit_n;
      if (v_i && chg_i) begin
        if (op_i == OP_ADD) begin
          if (br) rcnt_q[nd] <= rcnt_q[nd] + 1'b1;
          else    lcnt_q[nd] <= lcnt_q[nd] + 1'b1;
        end else if (op_i == OP_DEL) begin
          if (br) rcnt_q[nd] <= rcnt_q[nd] - 1'b1;
          else    lcnt_q[nd] <= lcnt_q[nd] - 1'b1;
        end
      end
    end
  end

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && chg_i && op_i == OP_DEL) |-> (sel_cnt != '0));

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && chg_i && op_i == OP_ADD) |-> (sel_cnt < CAP));
endmodule

// File: rtl/abm_leaf.sv
module abm_leaf
  import abm_pkg::*;
#(
  parameter int N = 128,
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [$clog2(N)-1:0] rd_idx_i,
  output logic                 rd_bit_o,
  input  logic                 v_i,
  input  abm_op_e              op_i,
  input  logic [$clog2(N)-1:0] idx_i,
  input  logic                 chg_i,
  input  logic                 hit_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_hit_o,
  output logic [$clog2(N)-1:0] rsp_idx_o
);
  localparam int IW = $clog2(N);
  localparam int WB = $clog2(W);
  localparam int NL = N / W;

  logic [W-1:0]     words_q [NL];
  logic [IW-WB-1:0] wd;
  logic [WB-1:0]    bt;
  logic [W-1:0]     cur;
  logic [WB-1:0]    lo;

  assign rd_bit_o = words_q[rd_idx_i[IW-1:WB]][rd_idx_i[WB-1:0]];

  always_comb begin
    wd  = idx_i[IW-1:WB];
    bt  = idx_i[WB-1:0];
    cur = words_q[wd];
    lo  = '0;
    for (int b = W - 1; b >= 0; b--)
      if (cur[b]) lo = WB'(b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NL; k++) words_q[k] <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= v_i;
      rsp_hit_o   <= hit_i;
      if (op_i == OP_FIND) rsp_idx_o <= hit_i ? {wd, lo} : '0;
      else                 rsp_idx_o <= idx_i;
      if (v_i && chg_i) words_q[wd][bt] <= (op_i == OP_ADD);
    end
  end

  a_r3_add_only_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && chg_i && op_i == OP_ADD) |-> !cur[bt]);

  a_r4_del_only_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && chg_i && op_i == OP_DEL) |-> cur[bt]);

  a_r10_find_word_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && hit_i && op_i == OP_FIND) |-> (cur != '0));
endmodule

// File: rtl/abm_set_tracker.sv
module abm_set_tracker
  import abm_pkg::*;
#(
  parameter int N = 128,
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [1:0]           cmd_op_i,
  input  logic [$clog2(N)-1:0] cmd_idx_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_hit_o,
  output logic [$clog2(N)-1:0] rsp_idx_o
);
  localparam int IW = $clog2(N);
  localparam int LV = $clog2(N / W);

  abm_op_e       in_op;
  logic [IW-1:0] in_idx;
  logic          in_chg, in_hit, pre, rd_bit;

  logic          p_v   [1:LV];
  abm_op_e       p_op  [1:LV];
  logic [IW-1:0] p_idx [1:LV];
  logic          p_chg [1:LV];
  logic          p_hit [1:LV];

  assign cmd_ready_o = 1'b1;

  // leaf bit at issue, overridden by the newest in-flight writer of the same index
  always_comb begin
    in_op = abm_op_e'(cmd_op_i);
    pre   = rd_bit;
    for (int k = LV; k >= 1; k--)
      if (p_v[k] && p_chg[k] && p_idx[k] == cmd_idx_i)
        pre = (p_op[k] == OP_ADD);
    in_chg = ((in_op == OP_ADD) && !pre) || ((in_op == OP_DEL) && pre);
    in_idx = (in_op == OP_FIND) ? '0 : cmd_idx_i;
    case (in_op)
      OP_TEST: in_hit = pre;
      OP_FIND: in_hit = 1'b1;
      default: in_hit = in_chg;
    endcase
  end

  for (genvar g = 0; g < LV; g++) begin : g_lvl
    if (g == 0) begin : g_root
      abm_level #(.N(N), .LVL(0)) u_lvl (
        .clk_i, .rst_ni,
        .v_i(cmd_valid_i), .op_i(in_op), .idx_i(in_idx), .chg_i(in_chg), .hit_i(in_hit),
        .v_o(p_v[1]), .op_o(p_op[1]), .idx_o(p_idx[1]), .chg_o(p_chg[1]), .hit_o(p_hit[1])
      );
    end else begin : g_inner
      abm_level #(.N(N), .LVL(g)) u_lvl (
        .clk_i, .rst_ni,
        .v_i(p_v[g]), .op_i(p_op[g]), .idx_i(p_idx[g]), .chg_i(p_chg[g]), .hit_i(p_hit[g]),
        .v_o(p_v[g+1]), .op_o(p_op[g+1]), .idx_o(p_idx[g+1]), .chg_o(p_chg[g+1]),
        .hit_o(p_hit[g+1])
      );
    end
  end

  abm_leaf #(.N(N), .W(W)) u_leaf (
    .clk_i, .rst_ni,
    .rd_idx_i(cmd_idx_i), .rd_bit_o(rd_bit),
    .v_i(p_v[LV]), .op_i(p_op[LV]), .idx_i(p_idx[LV]), .chg_i(p_chg[LV]), .hit_i(p_hit[LV]),
    .rsp_valid_o, .rsp_hit_o, .rsp_idx_o
  );

  a_r7_rsp_from_leaf_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_v[LV] |=> rsp_valid_o);

  a_r7_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_v[LV] |=> !rsp_valid_o);
endmodule

// File: tb/sim_abm_set_tracker.sv
`timescale 1ns/1ps
module sim_abm_set_tracker;
  localparam int N  = 128;
  localparam int W  = 16;
  localparam int IW = $clog2(N);
  localparam int LAT = $clog2(N / W);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [1:0] cmd_op_i = 2'd0;
  logic [IW-1:0] cmd_idx_i = '0;
  logic rsp_valid_o, rsp_hit_o;
  logic [IW-1:0] rsp_idx_o;

  abm_set_tracker #(.N(N), .W(W)) u0 (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_idx_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_idx_o
  );

  always #2.5 clk = ~clk;

  int    cyc = 0, n_vec = 0, n_bad = 0;
  bit    checking = 0, done = 0;
  bit    model [N];
  int    q_due[$], q_idx[$];
  bit    q_hit[$];
  string q_tag[$];
  string phase = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk) if (checking) begin
    bit exp_v;
    exp_v = (q_due.size() > 0) && (q_due[0] == cyc);
    n_vec++;
    if (rsp_valid_o !== exp_v || cmd_ready_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R7 cyc %0d: valid=%b ready=%b expected valid=%b ready=1",
               cyc, rsp_valid_o, cmd_ready_o, exp_v);
    end
    if (exp_v) begin
      if (rsp_hit_o !== q_hit[0] || rsp_idx_o !== IW'(q_idx[0])) begin
        n_bad++;
        $display("FAIL %s cyc %0d: hit=%b idx=%0d expected hit=%b idx=%0d",
                 q_tag[0], cyc, rsp_hit_o, rsp_idx_o, q_hit[0], q_idx[0]);
      end
      void'(q_due.pop_front()); void'(q_idx.pop_front());
      void'(q_hit.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid_i = 1'b0;
    end
  endtask

  task automatic cmd(int op, int idx);
    bit h; int e; string t;
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_op_i    = 2'(op);
    cmd_idx_i   = IW'(idx);
    e = idx;
    case (op)
      0: begin h = !model[idx]; model[idx] = 1; t = h ? "R2" : "R3"; end
      1: begin h = model[idx];  model[idx] = 0; t = "R4"; end
      2: begin h = model[idx];  t = "R5"; end
      default: begin
        h = 0; e = 0; t = "R6";
        for (int k = N - 1; k >= 0; k--) if (model[k]) begin h = 1; e = k; end
      end
    endcase
    if (phase != "") t = phase;
    q_due.push_back(cyc + 1 + LAT);
    q_idx.push_back(e);
    q_hit.push_back(h);
    q_tag.push_back(t);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    n_vec++;
    if (rsp_valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rsp_valid=%b during reset, expected 0", rsp_valid_o);
    end
    rst_ni = 1'b1;
    checking = 1;
    idle(2);
    // R1: empty after reset
    phase = "R1";
    cmd(2, 0); cmd(2, N - 1); cmd(3, 0); cmd(2, 37);
    phase = "";
    idle(5);
    // R2..R6 directed
    cmd(0, 5); idle(4); cmd(0, 5); idle(4); cmd(2, 5);
    cmd(0, 100); cmd(3, 0); cmd(1, 5); cmd(1, 5); cmd(3, 0);
    cmd(2, 5); cmd(1, 100); cmd(3, 0);
    cmd(0, N - 1); cmd(3, 0); cmd(0, 0); cmd(3, 0); cmd(1, 0); cmd(1, N - 1);
    cmd(3, 0);
    idle(6);
    // R8: same-index bursts while earlier commands are in flight
    phase = "R8";
    cmd(0, 9); cmd(0, 9); cmd(2, 9); cmd(1, 9); cmd(1, 9); cmd(2, 9);
    cmd(0, 9); cmd(3, 0); cmd(1, 9); cmd(3, 0); cmd(0, 17); cmd(1, 17);
    cmd(0, 17); cmd(3, 0);
    phase = "";
    idle(6);
    // mixed traffic: narrow index range for hazards, then the full range
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = (k < 3000) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, N - 1));
      if ($urandom_range(0, 5) == 0) idle(1);
      else cmd(int'($urandom_range(0, 3)), r);
    end
    idle(LAT + 4);
    n_vec++;
    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL R7: %0d responses missing, expected 0", q_due.size());
    end
    summary();
  end
endmodule